// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Router

This block takes an interrupt command written by a sender unit and works out which of `N_UNITS` local interrupt units receive it. The command is written in two halves. The high half carries only the 8-bit destination and is stored. A write of the low half carries the vector, the delivery mode, the destination mode and the shorthand, and it starts routing. One clock later the block presents a per-unit deliver strobe with the vector and mode for fixed and lowest-priority interrupts. It also presents error and warning pulses for that command.

Each unit also has a startup handshake in three states: waiting for an init message, waiting for a start-up message, and started. An init message moves a unit from the first state to the second. A start-up message is honoured only in the second state. It moves the unit to started and reports the start page address, which is the vector shifted left by twelve bits. Logical addressing reads each unit's logical ID and destination-format model, and it supports both the flat and the cluster model.

Top module: `ipi_router`

## Requirements
- R1: A pulse on `cmd_lo_we_i` routes the command, and its results appear on the outputs after the next rising clock edge. A pulse on `cmd_hi_we_i` alone stores `dst_hi_i` and delivers nothing. When both are pulsed in the same cycle, routing uses the new destination.
- R2: `cmd_short_i` selects the targets as follows. 0 uses the destination field. 1 selects the sender `src_unit_i` only. 2 selects every unit. 3 selects every unit except the sender.
- R3: With shorthand 0 and physical mode (`cmd_logical_i`=0), the destination selects the unit with that index. An index of `N_UNITS` or more pulses `err_range_o` and delivers nothing.
- R4: With logical mode and a unit format model of 4'h0 (flat), the unit accepts when its 8-bit logical ID ANDed with the destination is nonzero.
- R5: With format model 4'hF (cluster), the unit accepts when the upper nibbles of its logical ID and the destination are equal and the lower nibbles have at least one common set bit.
- R6: A logical destination of 8'hFF is accepted by every unit, whatever its model. Any other model value on a unit addressed logically pulses `err_fmt_o`, and that unit does not accept. Other units are still served.
- R7: Delivery modes 0 (fixed) and 1 (lowest priority) pulse `dlv_o[i]` for every accepting unit, with `dlv_vec_o` and `dlv_mode_o` set to the command's values.
- R8: Delivery mode 5 (init) moves an accepting unit from state 0 (INIT) to state 1 (SIPI). An accepting unit in any other state keeps its state, and `warn_o` pulses.
- R9: Delivery mode 6 (start-up) is honoured only in state 1. It moves the unit to state 2 (STARTED), pulses `start_vld_o[i]` and sets `start_addr_o` to vector<<12. In any other state the unit is unchanged and `warn_o` pulses.
- R10: After reset every unit's state on `state_o` (2 bits per unit, unit i at bits 2i+1:2i) is 0, and all strobes and flags are low.
- R11: Shorthand 1 together with logical mode, or any delivery mode other than 0, 1, 5 or 6, pulses `err_unsup_o` and delivers nothing.
- R12: Each command gives at most one strobe per unit, lasting one cycle. There is no strobe in a cycle that does not follow a low-half write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_hi_we_i | input | 1 | High-half write: stores the destination |
| dst_hi_i | input | DST_W | Destination carried by the high half |
| cmd_lo_we_i | input | 1 | Low-half write: triggers routing |
| cmd_vec_i | input | VEC_W | Interrupt vector |
| cmd_mode_i | input | 3 | Delivery mode |
| cmd_logical_i | input | 1 | 1 = logical destination mode |
| cmd_short_i | input | 2 | Destination shorthand |
| src_unit_i | input | IDX_W | Index of the sending unit |
| log_id_i | input | N_UNITS*DST_W | Logical ID per unit |
| fmt_model_i | input | N_UNITS*FMT_W | Destination format model per unit |
| dlv_o | output | N_UNITS | Fixed/lowest-priority deliver strobe per unit |
| dlv_vec_o | output | VEC_W | Vector of the last routed command |
| dlv_mode_o | output | 3 | Delivery mode of the last routed command |
| state_o | output | 2*N_UNITS | Startup state per unit |
| start_vld_o | output | N_UNITS | Start-up accepted strobe per unit |
| start_addr_o | output | VEC_W+PAGE_SH | Start page address |
| err_range_o | output | 1 | Physical index out of range |
| err_fmt_o | output | 1 | Invalid format model on an addressed unit |
| err_unsup_o | output | 1 | Unsupported shorthand/mode combination |
| warn_o | output | 1 | Init or start-up message ignored due to state |

## Verification
The hardest situations to reach are the handshake corners. One is a start-up message arriving before any init. Another is a repeated init on a unit already in SIPI state. A third is a broadcast init that reaches units in different states in the same command. The stimulus gets there by sending start-up and init messages to one unit out of order first, and then sending a shorthand-2 init. That broadcast finds unit 0 already advanced while the others are still waiting. Mixed flat and cluster models across units, plus one unit with an invalid model, exercise the logical match of every unit in one command.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  typedef enum logic [1:0] {
    SU_INIT    = 2'd0,
    SU_SIPI    = 2'd1,
    SU_STARTED = 2'd2
  } su_state_e;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWPRI = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_START  = 3'd6;

  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;
endpackage

// File: rtl/ipi_logical_match.sv
module ipi_logical_match #(
  parameter int DST_W = 8,
  parameter int FMT_W = 4
) (
  input  logic [DST_W-1:0] log_id_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [DST_W-1:0] dst_i,
  output logic             hit_o,
  output logic             fmt_bad_o
);
  localparam int HALF = DST_W / 2;

  logic bcast, is_flat, is_clus, flat_hit, clus_hit;

  always_comb begin
    bcast    = &dst_i;
    is_flat  = (fmt_i == '0);
    is_clus  = (fmt_i == '1);
    flat_hit = |(log_id_i & dst_i);
    clus_hit = (log_id_i[DST_W-1:HALF] == dst_i[DST_W-1:HALF]) &&
               (|(log_id_i[HALF-1:0] & dst_i[HALF-1:0]));
    hit_o     = bcast || (is_flat && flat_hit) || (is_clus && clus_hit);
    fmt_bad_o = !bcast && !is_flat && !is_clus;
  end
endmodule

// File: rtl/ipi_target_sel.sv
module ipi_target_sel
  import ipi_router_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DST_W   = 8,
  parameter int FMT_W   = 4,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [1:0]               short_i,
  input  logic                     logical_i,
  input  logic [DST_W-1:0]         dst_i,
  input  logic [IDX_W-1:0]         src_i,
  input  logic [N_UNITS*DST_W-1:0] log_id_i,
  input  logic [N_UNITS*FMT_W-1:0] fmt_i,
  output logic [N_UNITS-1:0]       accept_o,
  output logic                     err_range_o,
  output logic                     err_fmt_o,
  output logic                     unsup_o
);
  logic [N_UNITS-1:0] lhit, lbad;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_match
    ipi_logical_match #(.DST_W(DST_W), .FMT_W(FMT_W)) u_match (
      .log_id_i (log_id_i[g*DST_W +: DST_W]),
      .fmt_i    (fmt_i[g*FMT_W +: FMT_W]),
      .dst_i    (dst_i),
      .hit_o    (lhit[g]),
      .fmt_bad_o(lbad[g])
    );
  end

  always_comb begin
    accept_o    = '0;
    err_range_o = 1'b0;
    err_fmt_o   = 1'b0;
    unsup_o     = 1'b0;
    case (short_i)
      SH_NONE: begin
        if (logical_i) begin
          accept_o  = lhit;
          err_fmt_o = |lbad;
        end else begin
          err_range_o = ({1'b0, dst_i} >= (DST_W+1)'(N_UNITS));
          for (int i = 0; i < N_UNITS; i++)
            accept_o[i] = (dst_i == DST_W'(i));
        end
      end
      SH_SELF: begin
        unsup_o = logical_i;
        for (int i = 0; i < N_UNITS; i++)
          accept_o[i] = !logical_i && (src_i == IDX_W'(i));
      end
      SH_ALL: accept_o = '1;
      default: begin
        for (int i = 0; i < N_UNITS; i++)
          accept_o[i] = (src_i != IDX_W'(i));
      end
    endcase
  end
endmodule

// File: rtl/ipi_start_unit.sv
module ipi_start_unit
  import ipi_router_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [2:0] mode_i,
  output logic [1:0] state_o,
  output logic       start_o,
  output logic       warn_o
);
  su_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    warn_o  = 1'b0;
    if (hit_i) begin
      if (mode_i == DM_INIT) begin
        if (st_q == SU_INIT) st_d = SU_SIPI;
        else warn_o = 1'b1;
      end else if (mode_i == DM_START) begin
        if (st_q == SU_SIPI) begin
          st_d    = SU_STARTED;
          start_o = 1'b1;
        end else warn_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SU_INIT;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/ipi_router.sv
module ipi_router
  import ipi_router_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DST_W   = 8,
  parameter int FMT_W   = 4,
  parameter int VEC_W   = 8,
  parameter int PAGE_SH = 12,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_hi_we_i,
  input  logic [DST_W-1:0]           dst_hi_i,
  input  logic                       cmd_lo_we_i,
  input  logic [VEC_W-1:0]           cmd_vec_i,
  input  logic [2:0]                 cmd_mode_i,
  input  logic                       cmd_logical_i,
  input  logic [1:0]                 cmd_short_i,
  input  logic [IDX_W-1:0]           src_unit_i,
  input  logic [N_UNITS*DST_W-1:0]   log_id_i,
  input  logic [N_UNITS*FMT_W-1:0]   fmt_model_i,
  output logic [N_UNITS-1:0]         dlv_o,
  output logic [VEC_W-1:0]           dlv_vec_o,
  output logic [2:0]                 dlv_mode_o,
  output logic [2*N_UNITS-1:0]       state_o,
  output logic [N_UNITS-1:0]         start_vld_o,
  output logic [VEC_W+PAGE_SH-1:0]   start_addr_o,
  output logic                       err_range_o,
  output logic                       err_fmt_o,
  output logic                       err_unsup_o,
  output logic                       warn_o
);
  localparam int SA_W = VEC_W + PAGE_SH;

  logic [DST_W-1:0]   dst_q, dst_eff;
  logic [N_UNITS-1:0] accept, tgt, fix_hit, start_c, warn_c;
  logic               range_c, fmt_c, unsup_sh, mode_ok, is_fixed, unsup_c;

  assign dst_eff = cmd_hi_we_i ? dst_hi_i : dst_q;

  ipi_target_sel #(.N_UNITS(N_UNITS), .DST_W(DST_W), .FMT_W(FMT_W)) u_sel (
    .short_i    (cmd_short_i),
    .logical_i  (cmd_logical_i),
    .dst_i      (dst_eff),
    .src_i      (src_unit_i),
    .log_id_i   (log_id_i),
    .fmt_i      (fmt_model_i),
    .accept_o   (accept),
    .err_range_o(range_c),
    .err_fmt_o  (fmt_c),
    .unsup_o    (unsup_sh)
  );

  always_comb begin
    is_fixed = (cmd_mode_i == DM_FIXED) || (cmd_mode_i == DM_LOWPRI);
    mode_ok  = is_fixed || (cmd_mode_i == DM_INIT) || (cmd_mode_i == DM_START);
    unsup_c  = cmd_lo_we_i && (unsup_sh || !mode_ok);
    tgt      = (cmd_lo_we_i && !unsup_sh && mode_ok) ? accept : '0;
    fix_hit  = is_fixed ? tgt : '0;
  end

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    ipi_start_unit u_su (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (tgt[g]),
      .mode_i (cmd_mode_i),
      .state_o(state_o[2*g +: 2]),
      .start_o(start_c[g]),
      .warn_o (warn_c[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q        <= '0;
      dlv_o        <= '0;
      dlv_vec_o    <= '0;
      dlv_mode_o   <= '0;
      start_vld_o  <= '0;
      start_addr_o <= '0;
      err_range_o  <= 1'b0;
      err_fmt_o    <= 1'b0;
      err_unsup_o  <= 1'b0;
      warn_o       <= 1'b0;
    end else begin
      if (cmd_hi_we_i) dst_q <= dst_hi_i;
      if (cmd_lo_we_i) begin
        dlv_vec_o  <= cmd_vec_i;
        dlv_mode_o <= cmd_mode_i;
      end
      if (|start_c) start_addr_o <= SA_W'(cmd_vec_i) << PAGE_SH;
      dlv_o       <= fix_hit;
      start_vld_o <= start_c;
      err_range_o <= cmd_lo_we_i && range_c;
      err_fmt_o   <= cmd_lo_we_i && fmt_c;
      err_unsup_o <= unsup_c;
      warn_o      <= |warn_c;
    end
  end
endmodule

// File: rtl/ipi_router_chk.sv
module ipi_router_chk #(
  parameter int N_UNITS = 4,
  parameter int VEC_W   = 8,
  parameter int PAGE_SH = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmd_lo_we_i,
  input logic [VEC_W-1:0]         cmd_vec_i,
  input logic [N_UNITS-1:0]       dlv_o,
  input logic [2:0]               dlv_mode_o,
  input logic [2*N_UNITS-1:0]     state_o,
  input logic [N_UNITS-1:0]       start_vld_o,
  input logic [VEC_W+PAGE_SH-1:0] start_addr_o,
  input logic                     err_range_o,
  input logic                     err_unsup_o
);
  AST_DLV_AFTER_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dlv_o) |-> $past(cmd_lo_we_i)); // R1

  AST_DLV_MODE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dlv_o) |-> (dlv_mode_o <= 3'd1)); // R7

  AST_RANGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_range_o |-> (dlv_o == '0 && start_vld_o == '0)); // R3

  AST_UNSUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_unsup_o |-> (dlv_o == '0 && start_vld_o == '0)); // R11

  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dlv_o) && !cmd_lo_we_i) |=> (dlv_o == '0)); // R12

  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_vld_o) |-> (start_addr_o == {$past(cmd_vec_i), {PAGE_SH{1'b0}}})); // R9

  for (genvar g = 0; g < N_UNITS; g++) begin : g_chk
    AST_START_FROM_SIPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_vld_o[g] |-> (state_o[2*g +: 2] == 2'd2 && $past(state_o[2*g +: 2]) == 2'd1)); // R9

    AST_STATE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o[2*g +: 2] != $past(state_o[2*g +: 2])) |->
      ((state_o[2*g +: 2] == 2'd1 && $past(state_o[2*g +: 2]) == 2'd0) ||
       (state_o[2*g +: 2] == 2'd2 && $past(state_o[2*g +: 2]) == 2'd1))); // R8
  end
endmodule

bind ipi_router ipi_router_chk #(.N_UNITS(N_UNITS), .VEC_W(VEC_W), .PAGE_SH(PAGE_SH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_lo_we_i (cmd_lo_we_i),
  .cmd_vec_i   (cmd_vec_i),
  .dlv_o       (dlv_o),
  .dlv_mode_o  (dlv_mode_o),
  .state_o     (state_o),
  .start_vld_o (start_vld_o),
  .start_addr_o(start_addr_o),
  .err_range_o (err_range_o),
  .err_unsup_o (err_unsup_o)
);

// File: tb/tb_ipi_router.sv
`timescale 1ns/1ps
module tb_ipi_router;
  localparam int N = 4;
  localparam int TW = 31;
  localparam int NT = 12;
  // sh[30:29] lg[28] md[27:25] vec[24:17] dst[16:9] src[8:7] dlv[6:3] err{range,fmt,unsup}[2:0]
  localparam logic [TW-1:0] TBL [NT] = '{
    {2'd0, 1'b0, 3'd0, 8'h31, 8'h02, 2'd0, 4'b0100, 3'b000},  // R3 phys
    {2'd0, 1'b0, 3'd1, 8'h44, 8'h00, 2'd1, 4'b0001, 3'b000},  // R7 lowpri
    {2'd0, 1'b0, 3'd0, 8'h50, 8'h04, 2'd0, 4'b0000, 3'b100},  // R3 range
    {2'd0, 1'b1, 3'd0, 8'h61, 8'h06, 2'd0, 4'b0110, 3'b000},  // R4 flat
    {2'd0, 1'b1, 3'd0, 8'h62, 8'h10, 2'd0, 4'b0000, 3'b000},  // R4 no hit
    {2'd0, 1'b1, 3'd0, 8'h63, 8'hFF, 2'd0, 4'b1111, 3'b000},  // R6 bcast
    {2'd1, 1'b0, 3'd0, 8'h70, 8'h00, 2'd1, 4'b0010, 3'b000},  // R2 self
    {2'd2, 1'b0, 3'd0, 8'h71, 8'h00, 2'd3, 4'b1111, 3'b000},  // R2 all
    {2'd3, 1'b0, 3'd0, 8'h72, 8'h00, 2'd3, 4'b0111, 3'b000},  // R2 others
    {2'd1, 1'b1, 3'd0, 8'h73, 8'h00, 2'd0, 4'b0000, 3'b001},  // R11 self logical
    {2'd0, 1'b0, 3'd2, 8'h74, 8'h01, 2'd0, 4'b0000, 3'b001},  // R11 bad mode
    {2'd0, 1'b0, 3'd0, 8'h75, 8'hFF, 2'd0, 4'b0000, 3'b100}   // R3 phys FF
  };

  logic clk_i = 0, rst_ni = 0;
  logic cmd_hi_we_i = 0, cmd_lo_we_i = 0, cmd_logical_i = 0;
  logic [7:0] dst_hi_i = 0, cmd_vec_i = 0;
  logic [2:0] cmd_mode_i = 0;
  logic [1:0] cmd_short_i = 0, src_unit_i = 0;
  logic [N*8-1:0] log_id_i = {8'h08, 8'h04, 8'h02, 8'h01};
  logic [N*4-1:0] fmt_model_i = '0;
  logic [N-1:0] dlv_o, start_vld_o;
  logic [7:0] dlv_vec_o;
  logic [2:0] dlv_mode_o;
  logic [2*N-1:0] state_o;
  logic [19:0] start_addr_o;
  logic err_range_o, err_fmt_o, err_unsup_o, warn_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ipi_router dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] sh, logic lg, logic [2:0] md, logic [7:0] vec,
                      logic [7:0] dst, logic [1:0] src);
    @(negedge clk_i);
    cmd_hi_we_i = 1; dst_hi_i = dst;
    @(negedge clk_i);
    cmd_hi_we_i = 0;
    check("R1 hi-only", {28'd0, dlv_o}, 32'd0);
    cmd_lo_we_i = 1; cmd_short_i = sh; cmd_logical_i = lg; cmd_mode_i = md;
    cmd_vec_i = vec; src_unit_i = src;
    @(negedge clk_i);
    cmd_lo_we_i = 0;
  endtask

  function automatic logic [2:0] errs();
    return {err_range_o, err_fmt_o, err_unsup_o};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 state", {24'd0, state_o}, 32'd0);
    check("R10 dlv", {28'd0, dlv_o}, 32'd0);
    check("R10 flags", {28'd0, errs(), warn_o}, 32'd0);
    rst_ni = 1;

    for (int k = 0; k < NT; k++) begin
      logic [TW-1:0] e;
      e = TBL[k];
      send(e[30:29], e[28], e[27:25], e[24:17], e[16:9], e[8:7]);
      check("R2/R3/R4/R7 dlv", {28'd0, dlv_o}, {28'd0, e[6:3]});
      check("R3/R6/R11 err", {29'd0, errs()}, {29'd0, e[2:0]});
      if (e[6:3] != 0) check("R7 vec", {24'd0, dlv_vec_o}, {24'd0, e[24:17]});
      @(negedge clk_i);
      check("R12 one-shot", {28'd0, dlv_o}, 32'd0);
    end

    // R5 cluster: units 1,2 cluster; unit0/3 flat
    log_id_i = {8'h08, 8'h32, 8'h21, 8'h01};
    fmt_model_i = {4'h0, 4'hF, 4'hF, 4'h0};
    send(2'd0, 1'b1, 3'd0, 8'h80, 8'h23, 2'd0);
    check("R5 cluster", {28'd0, dlv_o}, 32'h3);
    check("R5 no err", {29'd0, errs()}, 32'd0);

    // R6 bad model on unit3
    fmt_model_i = {4'h5, 4'hF, 4'hF, 4'h0};
    send(2'd0, 1'b1, 3'd0, 8'h81, 8'h01, 2'd0);
    check("R6 bad fmt dlv", {28'd0, dlv_o}, 32'h1);
    check("R6 bad fmt flag", {31'd0, err_fmt_o}, 32'd1);
    fmt_model_i = '0;
    log_id_i = {8'h08, 8'h04, 8'h02, 8'h01};

    // R9 start-up before init: ignored
    send(2'd0, 1'b0, 3'd6, 8'h11, 8'h00, 2'd0);
    check("R9 early start warn", {31'd0, warn_o}, 32'd1);
    check("R9 early start state", {24'd0, state_o}, 32'd0);
    check("R9 early start vld", {28'd0, start_vld_o}, 32'd0);
    // R8 init
    send(2'd0, 1'b0, 3'd5, 8'h00, 8'h00, 2'd0);
    check("R8 init state", {24'd0, state_o}, 32'h01);
    check("R8 init nowarn", {31'd0, warn_o}, 32'd0);
    send(2'd0, 1'b0, 3'd5, 8'h00, 8'h00, 2'd0);
    check("R8 repeat init warn", {31'd0, warn_o}, 32'd1);
    check("R8 repeat init state", {24'd0, state_o}, 32'h01);
    // R9 start-up
    send(2'd0, 1'b0, 3'd6, 8'h9A, 8'h00, 2'd0);
    check("R9 start state", {24'd0, state_o}, 32'h02);
    check("R9 start vld", {28'd0, start_vld_o}, 32'h1);
    check("R9 start addr", {12'd0, start_addr_o}, 32'h9A000);
    check("R7 no fixed dlv on start", {28'd0, dlv_o}, 32'd0);
    // R8 broadcast init: units 1..3 advance, unit0 warns
    send(2'd2, 1'b0, 3'd5, 8'h00, 8'h00, 2'd0);
    check("R8 bcast init state", {24'd0, state_o}, 32'h56);
    check("R8 bcast init warn", {31'd0, warn_o}, 32'd1);

    // R1 simultaneous hi and lo: new destination used
    @(negedge clk_i);
    cmd_hi_we_i = 1; dst_hi_i = 8'h03; cmd_lo_we_i = 1;
    cmd_short_i = 0; cmd_logical_i = 0; cmd_mode_i = 0; cmd_vec_i = 8'hC3;
    @(negedge clk_i);
    cmd_hi_we_i = 0; cmd_lo_we_i = 0;
    check("R1 same-cycle dst", {28'd0, dlv_o}, 32'h8);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule